// File: doc/BRIEF.md
# Packed 16-bit Multiply-Accumulate Unit

This block multiplies two 64-bit operands lane by lane. Each operand holds four signed 16-bit lanes. One set of four lane multipliers forms 32-bit signed products. An opcode then selects the result format:

- the low half of every product, one per lane;
- the high half of every product, one per lane;
- the full products summed in adjacent pairs, giving two 32-bit results.

The unit sits in a media execution pipeline. A caller raises a one-cycle strobe together with the opcode and both operands. The result comes back with a valid flag exactly two cycles later. There is no back-pressure, and a new operation may be issued on every cycle.

Top module: `pmac_unit`

## Requirements
- R1: With opcode 2'b00, each 16-bit result lane i (bits 16i+15..16i) holds bits 15..0 of the signed product of operand lanes i.
- R2: With opcode 2'b01, each 16-bit result lane i holds bits 31..16 of the signed 32-bit product of operand lanes i.
- R3: With opcode 2'b10, result bits 31..0 hold the sum of the products of lanes 0 and 1, and result bits 63..32 hold the sum of the products of lanes 2 and 3. Each sum is taken modulo 2^32, so four lanes of 8000h give 80000000h in both halves.
- R4: A result appears with out_valid high on the second rising edge after the edge that samples in_valid high. out_valid stays low at the first of those edges.
- R5: Operations issued on consecutive cycles return on consecutive cycles, in issue order, each with its own correct result.
- R6: While rst is high (synchronous, active high), out_valid and out_data are zero on the following edge.
- R7: When no operation completes, out_valid is low and out_data keeps the last result. Changes to in_op, in_a or in_b while in_valid is low have no effect on it.
- R8: Opcode 2'b11 is reserved. It yields a result of all zeros with out_valid high, at the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: issue an operation this cycle |
| in_op | input | 2 | 00 low halves, 01 high halves, 10 pair sums, 11 reserved |
| in_a | input | 64 | First operand, four signed 16-bit lanes |
| in_b | input | 64 | Second operand, four signed 16-bit lanes |
| out_valid | output | 1 | Result is valid this cycle |
| out_data | output | 64 | Result of the operation issued two cycles earlier |

## Verification
The hardest case to reach from the ports is the pair-sum overflow. It occurs only when both products of a pair are at their most positive value, which the single input pattern of 8000h in every lane produces. A second vector mixes 7FFFh and 8000h to take a pair sum negative through cancellation. Pipeline overlap is reached by issuing three different opcodes on consecutive cycles. Each result is then checked on its own cycle. The operands are also changed while the strobe is low, to show that the held result does not change.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

    // Default geometry of the unit
    localparam int PM_LANE_W = 16;
    localparam int PM_LANES  = 4;

    // Result format selector
    typedef enum logic [1:0] {
        PM_MUL_LO  = 2'b00,
        PM_MUL_HI  = 2'b01,
        PM_MUL_ADD = 2'b10,
        PM_RSVD    = 2'b11
    } pm_op_e;

    // Control travelling alongside the products in stage one
    typedef struct packed {
        logic   valid;
        pm_op_e op;
    } pm_ctl_t;

    // Decode of the raw opcode bits into the enum
    function automatic pm_op_e pm_decode(input logic [1:0] raw);
        pm_op_e op;
        case (raw)
            2'b00:   op = PM_MUL_LO;
            2'b01:   op = PM_MUL_HI;
            2'b10:   op = PM_MUL_ADD;
            default: op = PM_RSVD;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/pmac_lane_mul.sv
module pmac_lane_mul
    import pmac_pkg::*;
#(
    parameter int LANE_W = PM_LANE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [LANE_W-1:0]     op_a,
    input  logic [LANE_W-1:0]     op_b,
    output logic [2*LANE_W-1:0]   prod
);
    localparam int PROD_W = 2 * LANE_W;

    logic signed [PROD_W-1:0] ext_a;
    logic signed [PROD_W-1:0] ext_b;
    logic signed [PROD_W-1:0] full;

    // Sign-extend to product width so the multiply keeps every bit
    always_comb begin
        ext_a = PROD_W'($signed(op_a));
        ext_b = PROD_W'($signed(op_b));
        full  = ext_a * ext_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod <= '0;
        end else if (load) begin
            prod <= full;
        end
    end

endmodule

// File: rtl/pmac_result_fmt.sv
module pmac_result_fmt
    import pmac_pkg::*;
#(
    parameter int LANES  = PM_LANES,
    parameter int LANE_W = PM_LANE_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  pm_ctl_t                           ctl,
    input  logic [LANES-1:0][2*LANE_W-1:0]    prods,
    output logic                              res_valid,
    output logic [LANES*LANE_W-1:0]           res_data
);
    localparam int PROD_W = 2 * LANE_W;
    localparam int DATA_W = LANES * LANE_W;
    localparam int PAIRS  = LANES / 2;

    logic [DATA_W-1:0] lo_vec;
    logic [DATA_W-1:0] hi_vec;
    logic [DATA_W-1:0] sum_vec;
    logic [DATA_W-1:0] next_data;

    // Per-lane half selection
    for (genvar g = 0; g < LANES; g++) begin : g_half
        assign lo_vec[g*LANE_W +: LANE_W] = prods[g][LANE_W-1:0];
        assign hi_vec[g*LANE_W +: LANE_W] = prods[g][PROD_W-1:LANE_W];
    end

    // Adjacent pair sums, wrapping modulo 2^PROD_W
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign sum_vec[p*PROD_W +: PROD_W] = prods[2*p] + prods[2*p+1];
    end

    always_comb begin
        case (ctl.op)
            PM_MUL_LO:  next_data = lo_vec;
            PM_MUL_HI:  next_data = hi_vec;
            PM_MUL_ADD: next_data = sum_vec;
            default:    next_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= ctl.valid;
            if (ctl.valid) begin
                res_data <= next_data;
            end
        end
    end

    // Idle stage one leaves the result untouched and invalid
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !ctl.valid |=> (!res_valid && $stable(res_data)));

    // Reserved opcode produces zeros
    assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl.valid && ctl.op == PM_RSVD) |=> (res_valid && res_data == '0));

    // Stage one valid always reaches the output one edge later
    assert_stage_valid_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.valid |=> res_valid);

endmodule

// File: rtl/pmac_unit.sv
module pmac_unit
    import pmac_pkg::*;
#(
    parameter int LANES  = PM_LANES,
    parameter int LANE_W = PM_LANE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [1:0]                 in_op,
    input  logic [LANES*LANE_W-1:0]    in_a,
    input  logic [LANES*LANE_W-1:0]    in_b,
    output logic                       out_valid,
    output logic [LANES*LANE_W-1:0]    out_data
);
    localparam int PROD_W = 2 * LANE_W;
    localparam int TOP    = LANES - 1;

    pm_ctl_t                        s1_ctl;
    logic [LANES-1:0][PROD_W-1:0]   s1_prod;

    // Stage one: control register
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_ctl <= '{valid: 1'b0, op: PM_MUL_LO};
        end else begin
            s1_ctl.valid <= in_valid;
            if (in_valid) begin
                s1_ctl.op <= pm_decode(in_op);
            end
        end
    end

    // Stage one: lane multipliers
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pmac_lane_mul #(.LANE_W(LANE_W)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .load (in_valid),
            .op_a (in_a[g*LANE_W +: LANE_W]),
            .op_b (in_b[g*LANE_W +: LANE_W]),
            .prod (s1_prod[g])
        );
    end

    // Stage two: format selection and pair sums
    pmac_result_fmt #(.LANES(LANES), .LANE_W(LANE_W)) u_fmt (
        .clk       (clk),
        .rst       (rst),
        .ctl       (s1_ctl),
        .prods     (s1_prod),
        .res_valid (out_valid),
        .res_data  (out_data)
    );

    // Port-level reference products for the checks below
    logic signed [PROD_W-1:0] ref_p0;
    logic signed [PROD_W-1:0] ref_p1;
    logic signed [PROD_W-1:0] ref_ptop;
    always_comb begin
        ref_p0   = PROD_W'($signed(in_a[LANE_W-1:0]))
                 * PROD_W'($signed(in_b[LANE_W-1:0]));
        ref_p1   = PROD_W'($signed(in_a[2*LANE_W-1:LANE_W]))
                 * PROD_W'($signed(in_b[2*LANE_W-1:LANE_W]));
        ref_ptop = PROD_W'($signed(in_a[TOP*LANE_W +: LANE_W]))
                 * PROD_W'($signed(in_b[TOP*LANE_W +: LANE_W]));
    end

    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    assert_idle_latency_R4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    assert_low_half_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b00) |-> ##2
        (out_data[LANE_W-1:0] == $past(ref_p0[LANE_W-1:0], 2)));

    assert_high_half_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b01) |-> ##2
        (out_data[TOP*LANE_W +: LANE_W] == $past(ref_ptop[PROD_W-1:LANE_W], 2)));

    assert_pair_sum_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b10) |-> ##2
        (out_data[PROD_W-1:0] == $past(ref_p0 + ref_p1, 2)));

endmodule

// File: tb/test_pmac_unit.sv
`timescale 1ns/1ps
module test_pmac_unit;

    typedef struct packed {
        logic [1:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 64'h0003_0002_FFFF_0005, 64'h0004_0007_0002_0006, 64'h000C_000E_FFFE_001E},
        '{2'b01, 64'h0003_0002_FFFF_0005, 64'h0004_0007_0002_0006, 64'h0000_0000_FFFF_0000},
        '{2'b01, 64'h7FFF_8000_4000_0100, 64'h7FFF_8000_4000_0100, 64'h3FFF_4000_1000_0001},
        '{2'b00, 64'h7FFF_8000_4000_0100, 64'h7FFF_8000_4000_0100, 64'h0001_0000_0000_0000},
        '{2'b10, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005, 64'h00000035_00000011},
        '{2'b10, 64'hFFFF_0002_FFFE_0003, 64'h0010_0010_0005_0004, 64'h00000010_00000002},
        '{2'b10, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 64'h80000000_80000000},
        '{2'b10, 64'h8000_7FFF_0000_FFFF, 64'h7FFF_7FFF_1234_FFFF, 64'hFFFF8001_00000001},
        '{2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000000000000000},
        '{2'b01, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    pmac_unit i_pmac_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] op);
        case (op)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R8";
        endcase
    endfunction

    task automatic drive(input bit v, input vec_t t);
        in_valid = v;
        in_op    = t.op;
        in_a     = t.a;
        in_b     = t.b;
    endtask

    // Single operation: issue, confirm no early result, then check it
    task automatic run_one(input vec_t t);
        @(negedge clk);
        drive(1'b1, t);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R4 early valid", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        chk("R4 valid", {63'd0, out_valid}, 64'd1);
        chk(req_of(t.op), out_data, t.exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6: state after reset
        chk("R6 valid", {63'd0, out_valid}, 64'd0);
        chk("R6 data", out_data, 64'd0);

        // Table walk: R1, R2, R3, R8
        for (int i = 0; i < NV; i++) begin
            run_one(VECS[i]);
        end

        // R7: idle with changing operands keeps last result (vector 9)
        @(negedge clk);
        drive(1'b0, VECS[6]);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_op = 2'(k);
            in_a  = {4{16'h1357}};
            chk("R7 valid", {63'd0, out_valid}, 64'd0);
            chk("R7 data", out_data, VECS[NV-1].exp);
        end

        // R5: back-to-back issue of three differing operations
        @(negedge clk);
        drive(1'b1, VECS[0]);
        @(negedge clk);
        chk("R5 no early", {63'd0, out_valid}, 64'd0);
        drive(1'b1, VECS[4]);
        @(negedge clk);
        chk("R5 first valid", {63'd0, out_valid}, 64'd1);
        chk("R5 first", out_data, VECS[0].exp);
        drive(1'b1, VECS[2]);
        @(negedge clk);
        chk("R5 second valid", {63'd0, out_valid}, 64'd1);
        chk("R5 second", out_data, VECS[4].exp);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R5 third valid", {63'd0, out_valid}, 64'd1);
        chk("R5 third", out_data, VECS[2].exp);
        @(negedge clk);
        chk("R5 drain", {63'd0, out_valid}, 64'd0);

        // R3 corner again, then R6 mid-run reset clears the result
        run_one(VECS[6]);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R6 mid valid", {63'd0, out_valid}, 64'd0);
        chk("R6 mid data", out_data, 64'd0);
        rst = 1'b0;
        run_one(VECS[7]);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule